// File: doc/BRIEF.md
# Single-Phase Fan Commutation PWM Driver

This block drives the four switches of an H-bridge that feeds the single winding of a brushless fan. A synchronized Hall level picks which phase conducts. The high-side switch of that phase is held on steadily. The low-side switch of the same phase is chopped by an internal counter-based PWM. The switches of the idle phase stay off. A tachometer output repeats the Hall level.

Speed is asked for with an 8-bit code in which a larger value means a slower fan. A second code sets a floor on speed: the demand can never run slower than that floor. Codes at or above a fixed cut-off stop the chopping entirely, so the speed input can also disable the drive. Each Hall transition blanks all four switches for a programmable number of clock cycles before the new phase is driven. A drive-enable input, which a lock supervisor controls, removes all drive and leaves the tachometer running.

Top module: `fan_drive_core`

## Requirements
- R1: With drive enabled and no blanking in progress, a registered Hall level of 1 selects phase 2 (`ph2_hi_o`=1, `ph1_hi_o`=0), and a level of 0 selects phase 1 (`ph1_hi_o`=1, `ph2_hi_o`=0).
- R2: The high-side output of the active phase stays at 1 in every cycle of the PWM period, including cycles where the PWM is low.
- R3: The low-side output of the active phase equals the PWM level. The low-side output of the idle phase is always 0.
- R4: The duty code is 255 minus the effective speed code. The PWM is high when the counter is below the duty code, and it is high in every cycle when the duty code is 255.
- R5: When `speed_code_i` >= OFF_CODE (default 250), both low-side outputs are 0 whatever the floor is. The high-side outputs still commutate.
- R6: The effective speed code is the smaller of `speed_code_i` and `floor_code_i`, so the duty never falls below 255 minus `floor_code_i`.
- R7: `fg_o` equals the Hall input as sampled at the previous clock edge, whether drive is enabled or not.
- R8: When the registered Hall level changes, all four phase outputs are 0 for `dead_len_i` cycles, and then the new phase drives. A further Hall change during that window restarts the count. A value of 0 gives no blanking.
- R9: While `drive_en_i` is 0, all four phase outputs are 0.
- R10: The PWM counter is 0 after reset, advances by one each clock, and wraps from 255 to 0.
- R11: During reset, all five outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 1 | Synchronized Hall level |
| speed_code_i | input | 8 | Speed demand, larger is slower |
| floor_code_i | input | 8 | Slowest permitted speed code |
| drive_en_i | input | 1 | Drive permission from lock supervisor |
| dead_len_i | input | 4 | Blanking length in cycles after a Hall change |
| ph1_hi_o | output | 1 | Phase 1 high-side switch |
| ph2_hi_o | output | 1 | Phase 2 high-side switch |
| ph1_lo_o | output | 1 | Phase 1 low-side switch (PWM) |
| ph2_lo_o | output | 1 | Phase 2 low-side switch (PWM) |
| fg_o | output | 1 | Tachometer copy of the Hall level |

## Verification
Several properties are checked on every cycle: a low-side output is never on without its own high side, all drive is removed while the enable is low, the cut-off code silences both low sides, the duty respects the floor, and the tachometer lags the Hall input by one edge. The same per-cycle checks cover the start and the count-down of the blanking window and the steady advance of the counter. Some behaviours can only be shown by the bench's scenarios against its own model: that the exact duty fraction follows the inverted code, that the high side holds through an entire PWM period, that blanking lasts exactly the programmed length and restarts on a second Hall edge, and that the cut-off wins over the floor.

// File: rtl/fan_drv_pkg.sv
package fan_drv_pkg;
  typedef enum logic {
    PH_ONE = 1'b0,
    PH_TWO = 1'b1
  } phase_e;
endpackage

// File: rtl/fan_duty_map.sv
module fan_duty_map
  import fan_drv_pkg::*;
#(
  parameter int CW       = 8,
  parameter int OFF_CODE = 250
) (
  input  logic [CW-1:0] speed_code_i,
  input  logic [CW-1:0] floor_code_i,
  output logic [CW-1:0] duty_o,
  output logic          force_off_o
);
  localparam logic [CW-1:0] CODE_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] OFF_LIM  = CW'(OFF_CODE);

  // slower demand than the floor is pulled back to the floor
  function automatic logic [CW-1:0] clamp_code(input logic [CW-1:0] dem,
                                               input logic [CW-1:0] flr);
    return (dem > flr) ? flr : dem;
  endfunction

  // larger code means slower, so duty is the complement
  function automatic logic [CW-1:0] code_to_duty(input logic [CW-1:0] code);
    return CODE_MAX - code;
  endfunction

  assign duty_o      = code_to_duty(clamp_code(speed_code_i, floor_code_i));
  assign force_off_o = (speed_code_i >= OFF_LIM);
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] duty_i,
  input  logic          force_off_i,
  output logic [CW-1:0] cnt_o,
  output logic          pwm_o
);
  localparam logic [CW-1:0] CODE_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  function automatic logic pwm_level(input logic [CW-1:0] cnt,
                                     input logic [CW-1:0] duty);
    return (duty == CODE_MAX) || (cnt < duty);
  endfunction

  assign cnt_o = cnt_q;
  assign pwm_o = !force_off_i && pwm_level(cnt_q, duty_i);

  assert_cnt_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_full_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == CODE_MAX && !force_off_i) |-> pwm_o);
endmodule

// File: rtl/fan_commutator.sv
module fan_commutator
  import fan_drv_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hall_i,
  input  logic [DW-1:0] dead_len_i,
  output phase_e        phase_o,
  output logic          blank_o,
  output logic          fg_o
);
  logic          hall_q;
  logic [DW-1:0] dead_q;
  logic          hall_edge;

  assign hall_edge = (hall_i != hall_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hall_q <= 1'b0;
      dead_q <= '0;
    end else if (hall_edge) begin
      hall_q <= hall_i;
      dead_q <= dead_len_i;
    end else if (dead_q != '0) begin
      dead_q <= dead_q - 1'b1;
    end
  end

  assign phase_o = hall_q ? PH_TWO : PH_ONE;
  assign blank_o = (dead_q != '0);
  assign fg_o    = hall_q;

  assert_dead_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hall_edge && dead_len_i != '0) |=> blank_o);

  assert_dead_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_o && !hall_edge) |=> dead_q == $past(dead_q) - 1'b1);

  assert_fg_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fg_o == $past(hall_i));
endmodule

// File: rtl/fan_drive_core.sv
module fan_drive_core
  import fan_drv_pkg::*;
#(
  parameter int CW       = 8,
  parameter int DW       = 4,
  parameter int OFF_CODE = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hall_i,
  input  logic [CW-1:0] speed_code_i,
  input  logic [CW-1:0] floor_code_i,
  input  logic          drive_en_i,
  input  logic [DW-1:0] dead_len_i,
  output logic          ph1_hi_o,
  output logic          ph2_hi_o,
  output logic          ph1_lo_o,
  output logic          ph2_lo_o,
  output logic          fg_o
);
  localparam logic [CW-1:0] CODE_MAX = {CW{1'b1}};

  logic [CW-1:0] duty;
  logic          force_off;
  logic [CW-1:0] pwm_cnt;
  logic          pwm_on;
  phase_e        phase;
  logic          blank;
  logic          drive_ok;

  fan_duty_map #(.CW(CW), .OFF_CODE(OFF_CODE)) u_map (
    .speed_code_i (speed_code_i),
    .floor_code_i (floor_code_i),
    .duty_o       (duty),
    .force_off_o  (force_off)
  );

  fan_pwm_gen #(.CW(CW)) u_pwm (
    .clk         (clk),
    .rst_n       (rst_n),
    .duty_i      (duty),
    .force_off_i (force_off),
    .cnt_o       (pwm_cnt),
    .pwm_o       (pwm_on)
  );

  fan_commutator #(.DW(DW)) u_comm (
    .clk        (clk),
    .rst_n      (rst_n),
    .hall_i     (hall_i),
    .dead_len_i (dead_len_i),
    .phase_o    (phase),
    .blank_o    (blank),
    .fg_o       (fg_o)
  );

  assign drive_ok = rst_n && drive_en_i && !blank;

  assign ph1_hi_o = drive_ok && (phase == PH_ONE);
  assign ph2_hi_o = drive_ok && (phase == PH_TWO);
  assign ph1_lo_o = ph1_hi_o && pwm_on;
  assign ph2_lo_o = ph2_hi_o && pwm_on;

  assert_lo_needs_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph1_lo_o |-> ph1_hi_o) and (ph2_lo_o |-> ph2_hi_o));

  assert_one_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ph1_hi_o, ph2_hi_o}));

  assert_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en_i |-> !(ph1_hi_o || ph2_hi_o || ph1_lo_o || ph2_lo_o));

  assert_cutoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    force_off |-> !(ph1_lo_o || ph2_lo_o));

  assert_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> duty >= (CODE_MAX - floor_code_i));

  assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !(ph1_hi_o || ph2_hi_o));
endmodule

// File: tb/tb_fan_drive_core.sv
module tb_fan_drive_core;
  localparam int CLK_PERIOD = 10;
  localparam int OFF_CODE   = 250;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hall = 1'b0;
  logic [7:0] spd = 8'd0;
  logic [7:0] flr = 8'd255;
  logic       en = 1'b0;
  logic [3:0] dead = 4'd0;
  logic       ph1_hi, ph2_hi, ph1_lo, ph2_lo, fg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench reference state
  logic [7:0] m_cnt = 8'd0;
  logic       m_hall = 1'b0;
  int         m_dead = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fan_drive_core dut (
    .clk(clk), .rst_n(rst_n), .hall_i(hall), .speed_code_i(spd),
    .floor_code_i(flr), .drive_en_i(en), .dead_len_i(dead),
    .ph1_hi_o(ph1_hi), .ph2_hi_o(ph2_hi), .ph1_lo_o(ph1_lo),
    .ph2_lo_o(ph2_lo), .fg_o(fg)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 8'd0; m_hall = 1'b0; m_dead = 0;
    end else begin
      m_cnt = m_cnt + 8'd1;
      if (hall !== m_hall) begin
        m_hall = hall; m_dead = int'(dead);
      end else if (m_dead > 0) begin
        m_dead = m_dead - 1;
      end
    end
  end

  function automatic int eff_duty(input logic [7:0] s, input logic [7:0] f);
    int e;
    e = (int'(s) < int'(f)) ? int'(s) : int'(f);
    return 255 - e;
  endfunction

  function automatic bit exp_pwm();
    int d;
    if (int'(spd) >= OFF_CODE) return 1'b0;
    d = eff_duty(spd, flr);
    return (d == 255) || (int'(m_cnt) < d);
  endfunction

  task automatic cmp(input string tag, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit drv, e1h, e2h, p;
      string th, tl;
      if (!rst_n) begin
        cmp("R11", "ph1_hi", ph1_hi, 1'b0); cmp("R11", "ph2_hi", ph2_hi, 1'b0);
        cmp("R11", "ph1_lo", ph1_lo, 1'b0); cmp("R11", "ph2_lo", ph2_lo, 1'b0);
        cmp("R11", "fg", fg, 1'b0);
      end else begin
        drv = en && (m_dead == 0);
        p   = exp_pwm();
        e1h = drv && !m_hall;
        e2h = drv && m_hall;
        if (!en) begin th = "R9"; tl = "R9"; end
        else if (m_dead != 0) begin th = "R8"; tl = "R8"; end
        else begin
          th = p ? "R1" : "R2";
          if (int'(spd) >= OFF_CODE) tl = "R5";
          else if (spd > flr)        tl = "R6";
          else                       tl = "R4,R10";
        end
        cmp(th, "ph1_hi", ph1_hi, e1h);
        cmp(th, "ph2_hi", ph2_hi, e2h);
        cmp(e1h ? tl : "R3", "ph1_lo", ph1_lo, e1h && p);
        cmp(e2h ? tl : "R3", "ph2_lo", ph2_lo, e2h && p);
        cmp("R7", "fg", fg, m_hall);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    step(4);
    rst_n = 1'b1; en = 1'b1; dead = 4'd3;
    // R4 full duty at code 0, then half duty, then R10 wrap over periods
    spd = 8'd0;   flr = 8'd255; step(300);
    spd = 8'd128; step(520);
    // R5 cut-off, also with a floor that would otherwise apply
    spd = 8'd255; step(260);
    spd = 8'd252; flr = 8'd10; step(260);
    // R6 floor clamps a slow demand
    spd = 8'd200; flr = 8'd100; step(300);
    // R8 Hall change with blanking, and restart within the window
    hall = 1'b1; step(2);
    hall = 1'b0; step(1);
    hall = 1'b1; step(40);
    dead = 4'd0; hall = 1'b0; step(20);
    dead = 4'd15; hall = 1'b1; step(30);
    // R9 and R7: disabled drive, tachometer still follows
    en = 1'b0;
    for (int k = 0; k < 6; k++) begin hall = ~hall; step(5); end
    en = 1'b1; step(30);
    // random mix
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 39) == 0) hall = ~hall;
      if ($urandom_range(0, 299) == 0) spd = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 299) == 0) flr = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 499) == 0) en = ~en;
      if ($urandom_range(0, 199) == 0) dead = 4'($urandom_range(0, 15));
      step(1);
    end
    // reset again mid-run
    rst_n = 1'b0; step(3);
    rst_n = 1'b1; step(20);
    finish_run();
  end
endmodule